// File: doc/BRIEF.md
# Descriptor Ring Fetch Controller

This block walks a circular ring of fixed-size DMA descriptors for a single channel. Software sets where the ring starts, how many entries it has, and a tail address that marks one entry past the last descriptor it has prepared. Every entry from the current position up to, but not including, the tail is available to the engine. The block issues one descriptor fetch address at a time over a request/acknowledge handshake and moves to the next entry after each acknowledge. It stops by itself when it catches up with the tail, and starts again when software moves the tail forward.

The block does not depend on direction. A transmit channel and a receive channel each use their own instance. The slot comparison uses entry indices measured from the ring start, so a tail that has wrapped past the end of the ring is handled the same way as one that has not. Each descriptor takes 16 bytes. A run bit lets software stop fetching without losing its place.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset, `suspended` is 1, `fetch_req` is 0 and `cur_ptr` is 0. The ring length field resets to all ones and the run bit resets to 0.
- R2: A write with `reg_wr_sel`=0 loads the ring start with the low 4 data bits cleared. It returns both the current entry and the tail to the ring start, so in the next cycle `cur_ptr` equals that aligned start and `suspended` is 1.
- R3: When the run bit is 1, the block is not suspended and no fetch is outstanding, `fetch_req` rises with `fetch_addr` equal to `cur_ptr`. Both hold steady until `fetch_ack` is seen high.
- R4: An accepted fetch (`fetch_req` and `fetch_ack` both high at a clock edge) moves `cur_ptr` forward by 16 in the following cycle.
- R5: A write with `reg_wr_sel`=1 sets the ring size from its low IDX_W data bits, as the entry count minus one. After the last entry is fetched, `cur_ptr` wraps to the ring start.
- R6: `suspended` is 1 exactly when the current entry equals the tail entry. No new fetch request starts while it is 1.
- R7: A write with `reg_wr_sel`=2 sets the tail entry to (data minus ring start)/16. A value equal to the entry count means entry 0. Entries are taken in ring order, so a tail below the current entry makes the engine fetch through the wrap. A tail equal to the current entry leaves the block suspended.
- R8: A write with `reg_wr_sel`=3 sets the run bit from data bit 0. Clearing it lets an outstanding fetch finish and advance, but no further request starts.
- R9: A ring-start write made while a fetch is outstanding leaves `fetch_req` and `fetch_addr` unchanged until the acknowledge. That acknowledge does not advance `cur_ptr`.
- R10: `fetch_req` falls in the cycle after an accepted fetch. The next request starts one cycle later at the earliest. With an immediate acknowledge, three owned entries drain and `suspended` returns to 1 six cycles after the tail write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 ring start, 1 size, 2 tail, 3 control |
| reg_wr_data | input | ADDR_W | Register write data |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | ADDR_W | Address of the descriptor to fetch |
| fetch_ack | input | 1 | Fetch accepted by the memory side |
| cur_ptr | output | ADDR_W | Address of the current descriptor |
| suspended | output | 1 | Current entry equals tail entry |

## Verification
A corrupted current index shows up at the ports within one cycle, because `cur_ptr` is rebuilt from it on every edge. It then shows up again in `fetch_addr` at the next request. A wrong tail index or wrap point shows up as `suspended` changing in the wrong cycle, or as an extra or missing request, because a drain always stops exactly where the tail entry lies. A lost discard flag after a ring-start write shows up as `cur_ptr` moving one entry past the new start in the cycle after the pending acknowledge.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;

  localparam int DESC_SHIFT = 4;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_TAIL = 2'd2,
    SEL_CTRL = 2'd3
  } ring_sel_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fetch_state_e;

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] base_d,
  output logic [IDX_W-1:0]  last_q,
  output logic [IDX_W-1:0]  tail_d,
  output logic              run_q,
  output logic              base_wr
);

  localparam int                SLOT_W     = IDX_W + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << DESC_SHIFT) - 1);

  logic [IDX_W-1:0]  last_d;
  logic [IDX_W-1:0]  tail_q;
  logic              run_d;
  logic [ADDR_W-1:0] tail_off;
  logic [SLOT_W-1:0] tail_slot;
  logic [SLOT_W-1:0] ring_entries;

  always_comb begin
    tail_off     = wr_data - base_q;
    tail_slot    = SLOT_W'(tail_off >> DESC_SHIFT);
    ring_entries = {1'b0, last_q} + SLOT_W'(1);
    base_d       = base_q;
    last_d       = last_q;
    tail_d       = tail_q;
    run_d        = run_q;
    base_wr      = 1'b0;
    if (wr_en) begin
      case (ring_sel_e'(wr_sel))
        SEL_BASE: begin
          base_d  = wr_data & ~ALIGN_MASK;
          tail_d  = '0;
          base_wr = 1'b1;
        end
        SEL_SIZE: last_d = wr_data[IDX_W-1:0];
        SEL_TAIL: tail_d = (tail_slot == ring_entries) ? '0 : tail_slot[IDX_W-1:0];
        SEL_CTRL: run_d  = wr_data[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      last_q <= '1;
      tail_q <= '0;
      run_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      last_q <= last_d;
      tail_q <= tail_d;
      run_q  <= run_d;
    end
  end

endmodule

// File: rtl/ring_cur_ptr.sv
module ring_cur_ptr
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_d,
  input  logic [IDX_W-1:0]  last_q,
  input  logic [IDX_W-1:0]  tail_d,
  input  logic              base_wr,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              suspended
);

  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] cur_d;

  always_comb begin
    cur_d = cur_q;
    if (base_wr)
      cur_d = '0;
    else if (advance)
      cur_d = (cur_q == last_q) ? '0 : cur_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q     <= '0;
      cur_ptr   <= '0;
      suspended <= 1'b1;
    end else begin
      cur_q     <= cur_d;
      cur_ptr   <= base_d + (ADDR_W'(cur_d) << DESC_SHIFT);
      suspended <= (cur_d == tail_d);
    end
  end

endmodule

// File: rtl/ring_fetch_fsm.sv
module ring_fetch_fsm
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              suspended,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic              base_wr,
  input  logic              fetch_ack,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              advance,
  output logic              drop_q
);

  fetch_state_e state_q;

  assign fetch_req = (state_q == FS_WAIT);
  assign advance   = fetch_req && fetch_ack && !drop_q && !base_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FS_IDLE;
      fetch_addr <= '0;
      drop_q     <= 1'b0;
    end else begin
      case (state_q)
        FS_IDLE: begin
          if (run && !suspended && !base_wr) begin
            state_q    <= FS_WAIT;
            fetch_addr <= cur_ptr;
          end
        end
        FS_WAIT: begin
          if (fetch_ack) begin
            state_q <= FS_IDLE;
            drop_q  <= 1'b0;
          end else if (base_wr) begin
            drop_q  <= 1'b1;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [ADDR_W-1:0] reg_wr_data,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              suspended
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  tail_d;
  logic              run_q;
  logic              base_wr;
  logic              advance;
  logic              drop_q;

  ring_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .base_q  (base_q),
    .base_d  (base_d),
    .last_q  (last_q),
    .tail_d  (tail_d),
    .run_q   (run_q),
    .base_wr (base_wr)
  );

  ring_cur_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .base_d    (base_d),
    .last_q    (last_q),
    .tail_d    (tail_d),
    .base_wr   (base_wr),
    .advance   (advance),
    .cur_ptr   (cur_ptr),
    .suspended (suspended)
  );

  ring_fetch_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .run        (run_q),
    .suspended  (suspended),
    .cur_ptr    (cur_ptr),
    .base_wr    (base_wr),
    .fetch_ack  (fetch_ack),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .advance    (advance),
    .drop_q     (drop_q)
  );

endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [1:0]        reg_wr_sel,
  input logic [ADDR_W-1:0] reg_wr_data,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_ack,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic              suspended,
  input logic [ADDR_W-1:0] base_q,
  input logic              drop_q
);

  logic start_wr;
  assign start_wr = reg_wr_en && (reg_wr_sel == 2'd0);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_ack && !drop_q && !start_wr |=>
      (cur_ptr == $past(fetch_addr) + ADDR_W'(16)) || (cur_ptr == base_q));

  p_start_write_r2: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> suspended && (cur_ptr == ($past(reg_wr_data) & ~ADDR_W'(15))));

  p_quiet_when_caught_up_r6: assert property (@(posedge clk) disable iff (rst)
    !fetch_req && suspended |=> !fetch_req);

  p_discarded_ack_r9: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_ack && drop_q && !start_wr |=> $stable(cur_ptr));

  p_req_falls_r10: assert property (@(posedge clk) disable iff (rst)
    fetch_req && fetch_ack |=> !fetch_req);

endmodule

bind desc_ring_fetch ring_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_sel  (reg_wr_sel),
  .reg_wr_data (reg_wr_data),
  .fetch_req   (fetch_req),
  .fetch_addr  (fetch_addr),
  .fetch_ack   (fetch_ack),
  .cur_ptr     (cur_ptr),
  .suspended   (suspended),
  .base_q      (base_q),
  .drop_q      (drop_q)
);

// File: tb/desc_ring_fetch_tb.sv
`timescale 1ns/1ps
module desc_ring_fetch_tb;

  localparam int AW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_wr_sel = '0;
  logic [AW-1:0] reg_wr_data = '0;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic          fetch_ack = 1'b0;
  logic [AW-1:0] cur_ptr;
  logic          suspended;

  int n_checks = 0;
  int n_fail   = 0;
  int n_acks   = 0;
  int ack_lat  = 2;
  bit ack_ok   = 1'b1;
  bit cmp_en   = 1'b0;

  // behavioural reference state
  logic [31:0] m_base, m_addr, exp_ptr;
  int          m_last, m_tail, m_cur;
  bit          m_run, m_req, m_drop, exp_susp;

  always #2.5 clk = ~clk;

  desc_ring_fetch #(.ADDR_W(AW), .IDX_W(IW)) u_dut (
    .clk (clk), .rst (rst),
    .reg_wr_en (reg_wr_en), .reg_wr_sel (reg_wr_sel), .reg_wr_data (reg_wr_data),
    .fetch_req (fetch_req), .fetch_addr (fetch_addr), .fetch_ack (fetch_ack),
    .cur_ptr (cur_ptr), .suspended (suspended)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    bit bw, ack_now, adv, issue;
    logic [31:0] ptr_old, off;
    int slot;
    if (rst) begin
      m_base = 0; m_last = 15; m_tail = 0; m_cur = 0;
      m_run = 0; m_req = 0; m_drop = 0; m_addr = 0;
      exp_ptr = 0; exp_susp = 1;
    end else begin
      bw      = reg_wr_en && (reg_wr_sel == 2'd0);
      ack_now = m_req && fetch_ack;
      adv     = ack_now && !m_drop && !bw;
      issue   = !m_req && m_run && (m_cur != m_tail) && !bw;
      ptr_old = m_base + 32'(m_cur * 16);
      if (ack_now) n_acks++;
      if (bw) m_cur = 0;
      else if (adv) m_cur = (m_cur == m_last) ? 0 : m_cur + 1;
      if (reg_wr_en) begin
        case (reg_wr_sel)
          2'd0: begin m_base = reg_wr_data & ~32'hF; m_tail = 0; end
          2'd1: m_last = int'(reg_wr_data & 32'hF);
          2'd2: begin
            off  = reg_wr_data - ptr_old + 32'(m_cur * 0) + (ptr_old - m_base) - (ptr_old - m_base);
            off  = reg_wr_data - m_base;
            slot = int'((off >> 4) & 32'h1F);
            m_tail = (slot == m_last + 1) ? 0 : (slot & 15);
          end
          default: m_run = reg_wr_data[0];
        endcase
      end
      if (ack_now) begin m_req = 0; m_drop = 0; end
      else if (m_req && bw) m_drop = 1;
      if (issue) begin m_req = 1; m_addr = ptr_old; end
      exp_ptr  = m_base + 32'(m_cur * 16);
      exp_susp = (m_cur == m_tail);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check("R3 fetch_req", {31'd0, fetch_req}, {31'd0, m_req});
      if (m_req) check("R3 fetch_addr", fetch_addr, m_addr);
      check("R4 cur_ptr", cur_ptr, exp_ptr);
      check("R6 suspended", {31'd0, suspended}, {31'd0, exp_susp});
    end
  end

  // memory-side responder
  initial begin
    int waited = 0;
    forever begin
      @(negedge clk);
      fetch_ack = 1'b0;
      if (fetch_req && ack_ok) begin
        if (waited >= ack_lat) begin
          fetch_ack = 1'b1;
          waited = 0;
        end else waited++;
      end else waited = 0;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_susp();
    for (int i = 0; i < 200; i++) begin
      if (suspended) return;
      @(negedge clk);
    end
    check("R6 drain timeout", {31'd0, suspended}, 32'd1);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 50; i++) begin
      if (fetch_req) return;
      @(negedge clk);
    end
    check("R3 request timeout", {31'd0, fetch_req}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    // R1 reset state
    check("R1 suspended", {31'd0, suspended}, 32'd1);
    check("R1 fetch_req", {31'd0, fetch_req}, 32'd0);
    check("R1 cur_ptr", cur_ptr, 32'd0);

    // R2 ring start with unaligned low bits
    wr(2'd0, 32'h1000_0007);
    check("R2 aligned start", cur_ptr, 32'h1000_0000);
    check("R2 suspended", {31'd0, suspended}, 32'd1);
    wr(2'd1, 32'd4);            // R5 five entries
    wr(2'd3, 32'd1);            // R8 run
    wr(2'd2, 32'h1000_0030);    // three owned entries
    wait_susp();
    check("R6 stop at tail", cur_ptr, 32'h1000_0030);
    check("R4 three fetches", 32'(n_acks), 32'd3);
    repeat (5) @(negedge clk);
    check("R6 no request while caught up", {31'd0, fetch_req}, 32'd0);

    // R5 / R7 tail equal to entry count means entry 0: wrap
    wr(2'd2, 32'h1000_0050);
    wait_susp();
    check("R5 wrapped to start", cur_ptr, 32'h1000_0000);
    check("R5 fetch count", 32'(n_acks), 32'd5);

    // R7 wrapped tail in ring order
    ack_lat = 0;
    wr(2'd2, 32'h1000_0030);
    wait_susp();
    wr(2'd2, 32'h1000_0010);
    wait_susp();
    check("R7 wrapped tail reached", cur_ptr, 32'h1000_0010);
    check("R7 fetch count", 32'(n_acks), 32'd11);
    wr(2'd2, 32'h1000_0010);
    check("R7 equal tail stays suspended", {31'd0, suspended}, 32'd1);
    repeat (3) @(negedge clk);
    check("R7 equal tail no request", {31'd0, fetch_req}, 32'd0);

    // R8 stop with a fetch outstanding
    ack_ok = 1'b0;
    wr(2'd2, 32'h1000_0040);
    wait_req();
    wr(2'd3, 32'd0);
    ack_ok = 1'b1;
    repeat (10) @(negedge clk);
    check("R8 outstanding fetch advanced", cur_ptr, 32'h1000_0020);
    check("R8 no new request", {31'd0, fetch_req}, 32'd0);
    check("R8 still owns entries", {31'd0, suspended}, 32'd0);

    // R9 ring start rewritten during an outstanding fetch
    ack_ok = 1'b0;
    wr(2'd3, 32'd1);
    wait_req();
    check("R3 issued address", fetch_addr, 32'h1000_0020);
    wr(2'd0, 32'h2000_0000);
    check("R9 request held", {31'd0, fetch_req}, 32'd1);
    check("R9 address held", fetch_addr, 32'h1000_0020);
    check("R2 new start", cur_ptr, 32'h2000_0000);
    ack_ok = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 ack does not advance", cur_ptr, 32'h2000_0000);
    check("R9 request cleared", {31'd0, fetch_req}, 32'd0);

    // R10 pacing with immediate acknowledge
    ack_lat = 0;
    wr(2'd2, 32'h2000_0030);
    repeat (5) @(posedge clk);
    #1;
    check("R10 still draining", {31'd0, suspended}, 32'd0);
    @(posedge clk);
    #1;
    check("R10 drained on time", {31'd0, suspended}, 32'd1);
    check("R10 final entry", cur_ptr, 32'h2000_0030);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule